// File: doc/BRIEF.md
# Multi-Deadline Compare and Update Engine

This block keeps up to seven 64-bit absolute deadlines and compares each of them against a 64-bit timebase supplied from outside. A deadline counts as reached once its value is less than or equal to the current time. What happens next depends on two per-deadline bits. A periodic deadline advances by its own 32-bit period. A one-shot deadline disarms its own interrupt enable. In both cases, if the deadline's interrupt was enabled, its pending flag is set. The interrupt output is high while any pending flag is set.

Software reaches the block through a 32-bit register port with a one-cycle write strobe and a combinational read. Every update a deadline can receive is done by a single write, so no read-modify-write sequence is needed. The updates are:

- a two-step 64-bit load through a scratch word;
- a load of current time plus an unsigned delay;
- a signed adjustment;
- a copy from the next-higher slot;
- a cancel.

A control word can make each kind of update also arm that deadline's interrupt. The timebase counter and the bus adapter live outside this block.

Top module: `deadline_engine`

## Requirements
- R1: After reset every deadline holds all ones, every period is zero, and the control word, scratch word, period-enable, interrupt-enable and pending masks are all zero. The interrupt output is low.
- R2: Deadline i is reached in a cycle when its value is less than or equal to the timebase and no register write is strobed in that cycle. In a write cycle no deadline is serviced.
- R3: A reached deadline whose period-enable bit is 0 sets its pending bit if its interrupt-enable bit is 1. In the same edge it clears its interrupt-enable bit.
- R4: A reached deadline whose period-enable bit is 1 is increased by its zero-extended 32-bit period. It sets its pending bit if its interrupt-enable bit is 1, and it keeps its interrupt-enable bit.
- R5: A write to the value word of a slot (offset +0x0) stores the data in bits 31:0 and the scratch word (0x18) in bits 63:32. A read of the value word returns bits 31:0 and, at the clock edge, copies bits 63:32 into the scratch word.
- R6: A write to the set word of a slot (offset +0x4) loads the deadline with the timebase plus the data, taken as unsigned 32-bit.
- R7: A write to the adjust word of a slot (offset +0x8) adds the data, sign-extended to 64 bits, to the deadline. A write to the period word (offset +0xC) stores the period.
- R8: Writing the copy word (0x2C) with bit i set loads slot i with the value slot i+1 held before the edge. Bit 6 and all higher bits are ignored.
- R9: Writing the cancel word (0x30) with bit i set clears both the interrupt-enable bit and the pending bit of slot i.
- R10: Writing the pending word (0x28) clears each pending bit written as 1 and leaves the others. The interrupt output equals the OR of all pending bits.
- R11: Control word (0x0C) bits 1, 2, 3 and 4 arm the interrupt enable of the slot modified by, respectively, a value-word write, a set write, an adjust write and a copy.
- R12: When several deadlines are reached in the same cycle, all of them are serviced at that edge.
- R13: The register map is: slot k (k = 0..6) at 0x80 + 0x10*k; period-enable mask 0x20; interrupt-enable mask 0x24; pending 0x28; control 0x0C; scratch 0x18. Mask bit i belongs to slot i. Addresses of a missing slot, and unaligned addresses, have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_i | input | 64 | Current timebase value |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational while rd_en is high |
| irq_o | output | 1 | Interrupt, OR of the pending flags |

## Verification
Read data is combinational, so a read is checked inside its own cycle, before the edge. The scratch latch that the same read causes is visible from the next cycle onward. Any write, and any deadline service, takes effect at the edge of the cycle that carries it. The bench therefore drives every vector at a falling edge and checks its read data 2 ns later. Each check then sees only the effect of earlier cycles. This matters for servicing: a read whose timebase reaches a deadline still shows the old pending mask, and only the following read shows the new one. The interrupt output follows the pending mask with no extra register, and it is sampled one full cycle after the service edge.

// File: rtl/dl_pkg.sv
package dl_pkg;
  localparam logic [7:0] A_CTRL    = 8'h0C;
  localparam logic [7:0] A_SCRATCH = 8'h18;
  localparam logic [7:0] A_PERIOD_EN = 8'h20;
  localparam logic [7:0] A_IRQ_EN  = 8'h24;
  localparam logic [7:0] A_PENDING = 8'h28;
  localparam logic [7:0] A_COPY    = 8'h2C;
  localparam logic [7:0] A_CANCEL  = 8'h30;

  // sub-word inside a slot, from address bits 3:2
  typedef enum logic [1:0] {
    OP_VAL = 2'd0,
    OP_SET = 2'd1,
    OP_ADD = 2'd2,
    OP_PER = 2'd3
  } dl_op_e;
endpackage

// File: rtl/dl_decode.sv
module dl_decode
  import dl_pkg::*;
#(
  parameter int N_DL = 7
) (
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [7:0]      addr,
  output logic [N_DL-1:0] wr_val,
  output logic [N_DL-1:0] wr_set,
  output logic [N_DL-1:0] wr_add,
  output logic [N_DL-1:0] wr_per,
  output logic [N_DL-1:0] rd_val,
  output logic [N_DL-1:0] rd_per,
  output logic            wr_ctrl,
  output logic            wr_scr,
  output logic            wr_pe,
  output logic            wr_ie,
  output logic            wr_ip,
  output logic            wr_copy,
  output logic            wr_cancel
);
  localparam int SLOT_W = 3;

  logic              aligned;
  logic              in_dl;
  logic [SLOT_W-1:0] slot;
  dl_op_e            op;

  assign aligned = (addr[1:0] == 2'b00);
  assign in_dl   = addr[7] & aligned;
  assign slot    = addr[6:4];
  assign op      = dl_op_e'(addr[3:2]);

  for (genvar i = 0; i < N_DL; i++) begin : g_slot_sel
    logic sel;
    assign sel       = in_dl && (slot == SLOT_W'(i));
    assign wr_val[i] = wr_en && sel && (op == OP_VAL);
    assign wr_set[i] = wr_en && sel && (op == OP_SET);
    assign wr_add[i] = wr_en && sel && (op == OP_ADD);
    assign wr_per[i] = wr_en && sel && (op == OP_PER);
    assign rd_val[i] = rd_en && sel && (op == OP_VAL);
    assign rd_per[i] = rd_en && sel && (op == OP_PER);
  end

  assign wr_ctrl   = wr_en && (addr == A_CTRL);
  assign wr_scr    = wr_en && (addr == A_SCRATCH);
  assign wr_pe     = wr_en && (addr == A_PERIOD_EN);
  assign wr_ie     = wr_en && (addr == A_IRQ_EN);
  assign wr_ip     = wr_en && (addr == A_PENDING);
  assign wr_copy   = wr_en && (addr == A_COPY);
  assign wr_cancel = wr_en && (addr == A_CANCEL);
endmodule

// File: rtl/dl_slot.sv
module dl_slot #(
  parameter int TW = 64,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] time_i,
  input  logic [DW-1:0] wdata,
  input  logic [TW-DW-1:0] scratch_i,
  input  logic [TW-1:0] nbr_i,
  input  logic          wr_val,
  input  logic          wr_set,
  input  logic          wr_add,
  input  logic          wr_per,
  input  logic          copy_i,
  input  logic          cmp_en,
  input  logic          pe_i,
  output logic [TW-1:0] dl_o,
  output logic [DW-1:0] per_o,
  output logic          reached_o
);
  localparam int HW = TW - DW;

  logic [TW-1:0] dl_q, dl_n;
  logic [DW-1:0] per_q;
  logic          dl_en;

  assign reached_o = cmp_en && (dl_q <= time_i);
  assign dl_en     = wr_val | wr_set | wr_add | copy_i | (reached_o & pe_i);

  always_comb begin
    dl_n = dl_q;
    if (wr_val)        dl_n = {scratch_i, wdata};
    else if (wr_set)   dl_n = time_i + TW'(wdata);
    else if (wr_add)   dl_n = dl_q + {{HW{wdata[DW-1]}}, wdata};
    else if (copy_i)   dl_n = nbr_i;
    else if (reached_o && pe_i) dl_n = dl_q + TW'(per_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dl_q  <= '1;
      per_q <= '0;
    end else begin
      if (dl_en)  dl_q  <= dl_n;
      if (wr_per) per_q <= wdata;
    end
  end

  assign dl_o  = dl_q;
  assign per_o = per_q;

  assert_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> dl_q == $past(time_i) + TW'($past(wdata)));

  assert_add_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_add |=> dl_q == $past(dl_q) + {{HW{$past(wdata[DW-1])}}, $past(wdata)});

  assert_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reached_o && pe_i) |=> dl_q == $past(dl_q) + TW'($past(per_q)));
endmodule

// File: rtl/dl_flags.sv
module dl_flags #(
  parameter int N_DL = 7,
  parameter int DW   = 32,
  parameter int HW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [DW-1:0]   wdata,
  input  logic            wr_ctrl,
  input  logic            wr_scr,
  input  logic            wr_pe,
  input  logic            wr_ie,
  input  logic            wr_ip,
  input  logic            wr_copy,
  input  logic            wr_cancel,
  input  logic [N_DL-1:0] wr_val,
  input  logic [N_DL-1:0] wr_set,
  input  logic [N_DL-1:0] wr_add,
  input  logic            rd_latch,
  input  logic [HW-1:0]   rd_hi,
  input  logic [N_DL-1:0] reached,
  output logic [3:0]      ctrl_o,
  output logic [DW-1:0]   scratch_o,
  output logic [N_DL-1:0] pe_o,
  output logic [N_DL-1:0] ie_o,
  output logic [N_DL-1:0] ip_o,
  output logic [N_DL-1:0] copy_o,
  output logic            irq_o
);
  logic [3:0]      ctrl_q;
  logic [DW-1:0]   scr_q, scr_n;
  logic            scr_en;
  logic [N_DL-1:0] pe_q, ie_q, ie_n, ip_q, ip_n;
  logic [N_DL-1:0] copy_mask, cancel_mask;

  always_comb begin
    copy_mask = '0;
    if (wr_copy) copy_mask[N_DL-2:0] = wdata[N_DL-2:0];
    cancel_mask = wr_cancel ? wdata[N_DL-1:0] : '0;
  end

  always_comb begin
    scr_en = wr_scr | rd_latch;
    scr_n  = wr_scr ? wdata : DW'(rd_hi);
  end

  always_comb begin
    ie_n = ie_q;
    if (wr_ie) ie_n = wdata[N_DL-1:0];
    ie_n = ie_n | (wr_val & {N_DL{ctrl_q[0]}}) | (wr_set & {N_DL{ctrl_q[1]}})
                | (wr_add & {N_DL{ctrl_q[2]}}) | (copy_mask & {N_DL{ctrl_q[3]}});
    ie_n = ie_n & ~cancel_mask & ~(reached & ~pe_q);
  end

  always_comb begin
    ip_n = ip_q;
    if (wr_ip) ip_n = ip_n & ~wdata[N_DL-1:0];
    ip_n = (ip_n & ~cancel_mask) | (reached & ie_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      scr_q  <= '0;
      pe_q   <= '0;
      ie_q   <= '0;
      ip_q   <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata[4:1];
      if (scr_en)  scr_q  <= scr_n;
      if (wr_pe)   pe_q   <= wdata[N_DL-1:0];
      ie_q <= ie_n;
      ip_q <= ip_n;
    end
  end

  assign ctrl_o    = ctrl_q;
  assign scratch_o = scr_q;
  assign pe_o      = pe_q;
  assign ie_o      = ie_q;
  assign ip_o      = ip_q;
  assign copy_o    = copy_mask;
  assign irq_o     = |ip_q;

  assert_oneshot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(reached & ~pe_q)) |=> ((ie_q & $past(reached & ~pe_q)) == '0));

  assert_nocmp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_ip && !wr_cancel) |=> ((ip_q & ~$past(ip_q)) == '0));

  assert_cancel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cancel |=> (((ie_q | ip_q) & $past(wdata[N_DL-1:0])) == '0));

  assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ip && !reached[0]) |=> !(ip_q[0] && $past(wdata[0])));
endmodule

// File: rtl/deadline_engine.sv
module deadline_engine
  import dl_pkg::*;
#(
  parameter int N_DL = 7,
  parameter int TW   = 64,
  parameter int DW   = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] time_i,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [7:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq_o
);
  localparam int HW = TW - DW;

  logic [N_DL-1:0] wr_val, wr_set, wr_add, wr_per, rd_val, rd_per;
  logic wr_ctrl, wr_scr, wr_pe, wr_ie, wr_ip, wr_copy, wr_cancel;
  logic [3:0]      ctrl;
  logic [DW-1:0]   scratch;
  logic [N_DL-1:0] pe, ie, ip, copy_vec, reached;
  logic [TW-1:0]   dl   [N_DL];
  logic [DW-1:0]   per  [N_DL];
  logic [HW-1:0]   rd_hi;
  logic            cmp_en;

  assign cmp_en = !wr_en;

  dl_decode #(.N_DL(N_DL)) u_decode (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_val(wr_val), .wr_set(wr_set), .wr_add(wr_add), .wr_per(wr_per),
    .rd_val(rd_val), .rd_per(rd_per),
    .wr_ctrl(wr_ctrl), .wr_scr(wr_scr), .wr_pe(wr_pe), .wr_ie(wr_ie),
    .wr_ip(wr_ip), .wr_copy(wr_copy), .wr_cancel(wr_cancel)
  );

  for (genvar i = 0; i < N_DL; i++) begin : g_slot
    logic [TW-1:0] nbr;
    if (i == N_DL - 1) begin : g_top
      assign nbr = dl[i];
    end else begin : g_mid
      assign nbr = dl[i+1];
    end
    dl_slot #(.TW(TW), .DW(DW)) u_slot (
      .clk(clk), .rst_n(rst_n), .time_i(time_i), .wdata(wdata),
      .scratch_i(scratch[HW-1:0]), .nbr_i(nbr),
      .wr_val(wr_val[i]), .wr_set(wr_set[i]), .wr_add(wr_add[i]),
      .wr_per(wr_per[i]), .copy_i(copy_vec[i]), .cmp_en(cmp_en),
      .pe_i(pe[i]), .dl_o(dl[i]), .per_o(per[i]), .reached_o(reached[i])
    );
  end

  always_comb begin
    rd_hi = '0;
    for (int i = 0; i < N_DL; i++) begin
      if (rd_val[i]) rd_hi = dl[i][TW-1:DW];
    end
  end

  dl_flags #(.N_DL(N_DL), .DW(DW), .HW(HW)) u_flags (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata),
    .wr_ctrl(wr_ctrl), .wr_scr(wr_scr), .wr_pe(wr_pe), .wr_ie(wr_ie),
    .wr_ip(wr_ip), .wr_copy(wr_copy), .wr_cancel(wr_cancel),
    .wr_val(wr_val), .wr_set(wr_set), .wr_add(wr_add),
    .rd_latch(|rd_val), .rd_hi(rd_hi), .reached(reached),
    .ctrl_o(ctrl), .scratch_o(scratch), .pe_o(pe), .ie_o(ie), .ip_o(ip),
    .copy_o(copy_vec), .irq_o(irq_o)
  );

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_CTRL:      rdata = DW'({ctrl, 1'b0});
        A_SCRATCH:   rdata = scratch;
        A_PERIOD_EN: rdata = DW'(pe);
        A_IRQ_EN:    rdata = DW'(ie);
        A_PENDING:   rdata = DW'(ip);
        default:     rdata = '0;
      endcase
      for (int i = 0; i < N_DL; i++) begin
        if (rd_val[i]) rdata = dl[i][DW-1:0];
        if (rd_per[i]) rdata = per[i];
      end
    end
  end

  assert_onehot_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_val, wr_set, wr_add, wr_per, wr_ctrl, wr_scr, wr_pe,
              wr_ie, wr_ip, wr_copy, wr_cancel}));
endmodule

// File: tb/deadline_engine_tb.sv
`timescale 1ns/1ps
module deadline_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] time_i;
  logic        wr_en, rd_en;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  deadline_engine u_dut (
    .clk(clk), .rst_n(rst_n), .time_i(time_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  a;
    logic [31:0] d;
    logic [63:0] t;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 52;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h28, 32'h0,        64'd100, 32'h0,        8'd1},  // R1 pending clear
    '{1'b0, 8'h80, 32'h0,        64'd100, 32'hFFFFFFFF, 8'd1},  // R1 deadline all ones
    '{1'b0, 8'h18, 32'h0,        64'd100, 32'hFFFFFFFF, 8'd5},  // R5 high word latched
    '{1'b1, 8'h18, 32'h1,        64'd100, 32'h0,        8'd5},
    '{1'b1, 8'h80, 32'h5,        64'd100, 32'h0,        8'd5},
    '{1'b0, 8'h80, 32'h0,        64'd100, 32'h5,        8'd5},  // R5
    '{1'b1, 8'h18, 32'h0,        64'd100, 32'h0,        8'd5},
    '{1'b0, 8'h80, 32'h0,        64'd100, 32'h5,        8'd5},
    '{1'b0, 8'h18, 32'h0,        64'd100, 32'h1,        8'd5},  // R5 high word from scratch
    '{1'b0, 8'h24, 32'h0,        64'd100, 32'h0,        8'd11}, // R11 no arm when ctrl 0
    '{1'b1, 8'h0C, 32'h1E,       64'd100, 32'h0,        8'd11},
    '{1'b0, 8'h0C, 32'h0,        64'd100, 32'h1E,       8'd13}, // R13
    '{1'b1, 8'h94, 32'd50,       64'd100, 32'h0,        8'd6},
    '{1'b0, 8'h24, 32'h0,        64'd100, 32'h2,        8'd11}, // R11 set arms
    '{1'b0, 8'h90, 32'h0,        64'd100, 32'd150,      8'd6},  // R6
    '{1'b1, 8'h98, 32'hFFFFFFF6, 64'd100, 32'h0,        8'd7},
    '{1'b0, 8'h90, 32'h0,        64'd100, 32'd140,      8'd7},  // R7 negative adjust
    '{1'b0, 8'h20, 32'h0,        64'd140, 32'h0,        8'd2},  // slot1 fires here
    '{1'b0, 8'h28, 32'h0,        64'd140, 32'h2,        8'd3},  // R3
    '{1'b0, 8'h24, 32'h0,        64'd140, 32'h0,        8'd3},  // R3 disarmed
    '{1'b1, 8'h28, 32'h2,        64'd140, 32'h0,        8'd10},
    '{1'b0, 8'h28, 32'h0,        64'd140, 32'h0,        8'd10}, // R10
    '{1'b1, 8'hAC, 32'd20,       64'd140, 32'h0,        8'd4},
    '{1'b1, 8'h20, 32'h4,        64'd140, 32'h0,        8'd4},
    '{1'b1, 8'hA4, 32'd10,       64'd140, 32'h0,        8'd4},
    '{1'b0, 8'h20, 32'h0,        64'd150, 32'h4,        8'd4},  // slot2 fires here
    '{1'b0, 8'hA0, 32'h0,        64'd150, 32'd170,      8'd4},  // R4 reloaded
    '{1'b0, 8'h28, 32'h0,        64'd150, 32'h4,        8'd4},  // R4
    '{1'b0, 8'h24, 32'h0,        64'd150, 32'h4,        8'd4},  // R4 stays armed
    '{1'b1, 8'h2C, 32'h2,        64'd150, 32'h0,        8'd8},
    '{1'b0, 8'h90, 32'h0,        64'd150, 32'd170,      8'd8},  // R8
    '{1'b0, 8'h24, 32'h0,        64'd150, 32'h6,        8'd11}, // R11 copy arms
    '{1'b1, 8'h2C, 32'h40,       64'd150, 32'h0,        8'd8},
    '{1'b0, 8'hE0, 32'h0,        64'd150, 32'hFFFFFFFF, 8'd8},  // R8 top bit ignored
    '{1'b0, 8'h24, 32'h0,        64'd150, 32'h6,        8'd8},
    '{1'b1, 8'h30, 32'h4,        64'd150, 32'h0,        8'd9},
    '{1'b0, 8'h28, 32'h0,        64'd150, 32'h0,        8'd9},  // R9
    '{1'b0, 8'h24, 32'h0,        64'd150, 32'h2,        8'd9},  // R9
    '{1'b1, 8'h18, 32'h0,        64'd170, 32'h0,        8'd2},  // write cycle: no service
    '{1'b0, 8'h28, 32'h0,        64'd170, 32'h0,        8'd2},  // R2
    '{1'b0, 8'h28, 32'h0,        64'd170, 32'h2,        8'd2},  // R2 serviced next
    '{1'b0, 8'hA0, 32'h0,        64'd170, 32'd190,      8'd4},  // R4
    '{1'b0, 8'h24, 32'h0,        64'd170, 32'h0,        8'd3},  // R3
    '{1'b1, 8'hB0, 32'd1000,     64'd170, 32'h0,        8'd11},
    '{1'b0, 8'h24, 32'h0,        64'd170, 32'h8,        8'd11}, // R11 value write arms
    '{1'b1, 8'hB8, 32'd24,       64'd170, 32'h0,        8'd7},
    '{1'b0, 8'hB0, 32'h0,        64'd170, 32'd1024,     8'd7},  // R7
    '{1'b1, 8'hE4, 32'hFFFFFFFF, 64'd170, 32'h0,        8'd6},
    '{1'b0, 8'hE0, 32'h0,        64'd170, 32'hA9,       8'd6},  // R6 unsigned delay
    '{1'b0, 8'h18, 32'h0,        64'd170, 32'h1,        8'd6},  // R6 carry into high word
    '{1'b1, 8'hF4, 32'h1,        64'd170, 32'h0,        8'd13},
    '{1'b0, 8'h24, 32'h0,        64'd170, 32'h48,       8'd13}  // R13 missing slot ignored
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_cyc(input logic [7:0] a, input logic [31:0] d, input logic [63:0] t);
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b0; addr = a; wdata = d; time_i = t;
  endtask

  task automatic rd_cyc(input logic [7:0] a, input logic [63:0] t,
                        input logic [31:0] exp, input string req);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b1; addr = a; wdata = '0; time_i = t;
    #2 check(rdata, exp, req);
  endtask

  task automatic idle(input logic [63:0] t);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; time_i = t;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; time_i = '0;
    repeat (3) @(negedge clk);
    check({31'b0, irq_o}, 32'h0, "R1 irq in reset");
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wr_en  = VECS[i].wr;
      rd_en  = !VECS[i].wr;
      addr   = VECS[i].a;
      wdata  = VECS[i].d;
      time_i = VECS[i].t;
      if (!VECS[i].wr) begin
        #2 check(rdata, VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
      end
    end
    idle(170);
    @(negedge clk);
    #2 check({31'b0, irq_o}, 32'h1, "R10 irq follows pending");

    // reset in mid-run clears everything (R1)
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check({31'b0, irq_o}, 32'h0, "R1 irq after reset");
    rd_cyc(8'h28, 0, 32'h0, "R1 pending");
    rd_cyc(8'h24, 0, 32'h0, "R1 irq enable");
    rd_cyc(8'h0C, 0, 32'h0, "R1 ctrl");
    rd_cyc(8'hAC, 0, 32'h0, "R1 period");
    rd_cyc(8'hA0, 0, 32'hFFFFFFFF, "R1 deadline");

    // two deadlines reached in one cycle, one equal and one already passed (R12)
    wr_cyc(8'h0C, 32'h04, 0);
    wr_cyc(8'h84, 32'd5, 0);
    wr_cyc(8'hC4, 32'd3, 0);
    idle(2);
    @(negedge clk);
    #2 check({31'b0, irq_o}, 32'h0, "R2 not yet reached");
    idle(5);
    rd_cyc(8'h28, 5, 32'h11, "R12 both serviced");
    check({31'b0, irq_o}, 32'h1, "R12 irq");
    rd_cyc(8'h24, 5, 32'h0, "R3 both disarmed");

    // partial write-one-to-clear (R10)
    wr_cyc(8'h28, 32'h01, 5);
    rd_cyc(8'h28, 5, 32'h10, "R10 one bit left");
    check({31'b0, irq_o}, 32'h1, "R10 irq held");
    wr_cyc(8'h28, 32'h10, 5);
    rd_cyc(8'h28, 5, 32'h0, "R10 all clear");
    check({31'b0, irq_o}, 32'h0, "R10 irq low");

    // unaligned write has no effect (R13)
    wr_cyc(8'h25, 32'h7F, 5);
    rd_cyc(8'h24, 5, 32'h0, "R13 unaligned ignored");

    finish_run();
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule